// File: doc/BRIEF.md
# Parallel Spare-Order Repair Analyzer

This block sits beside a memory self-test controller and decides, while the test is still running, whether a bit-oriented array with two redundant rows and two redundant columns can be fixed. It does no search once the test is over. Instead it runs six analysis engines side by side, one for each order in which the four spares could be handed out. Each engine keeps a small match register file for the rows it has replaced and another for the columns it has replaced. For every failing cell, each engine checks whether that cell is already covered. If it is not, the engine hands out the next spare in its own order.

The test controller pulses `init_i` before a test. It raises `fail_i` together with the failing row and column address for every miscompare. It pulses `done_i` when the test ends. From that edge on, the block holds a verdict: whether any order survived, the index of the lowest surviving order, and the row and column addresses that order stored. A repair controller can use these directly. The per-order failure vector stays live on `unsuc_o` the whole time.

Top module: `spare_order_analyzer`

## Requirements
- R1: There are six engines with fixed orders. The letter sequence gives the spare used on the first, second, third and fourth uncovered fail. Index 0 is RRCC, 1 is RCRC, 2 is RCCR, 3 is CRRC, 4 is CRCR and 5 is CCRR. Bit i of `unsuc_o` and the value i on `pick_o` both refer to index i.
- R2: A fail is covered for an engine when its column address equals a written column entry of that engine, or its row address equals a written row entry. A covered fail changes none of that engine's state.
- R3: An uncovered fail consumes the engine's next spare at the edge that samples it. A row spare writes the row address into the lowest free row slot, and a column spare writes the column address into the lowest free column slot. Slot 0 is in the low bits of the address output and in bit 0 of its valid output. Entries that have not been written never match.
- R4: An uncovered fail that arrives after all four spares are used sets the engine's `unsuc_o` bit at that edge. The bit stays set through any later fail until an initialize.
- R5: Reset, or `init_i` sampled high, clears every engine and the report in one edge. `init_i` wins over a `fail_i` or `done_i` in the same cycle.
- R6: A cycle with `fail_i` low (a pass) changes no engine state.
- R7: At the edge that samples `done_i`, `report_valid_o` goes to 1. `repair_ok_o` goes to 1 exactly when at least one `unsuc_o` bit was clear before that edge.
- R8: With `done_i` the block reports the lowest-index engine whose bit is clear: `pick_o`, its row and column entries, and their valid bits. If no engine survived, all of these outputs are zero.
- R9: The report keeps its value through later fails and passes until the next initialize or `done_i`, while `unsuc_o` keeps following the engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start-of-test clear strobe |
| fail_i | input | 1 | Miscompare strobe for the current address |
| row_i | input | ROW_W | Failing row address |
| col_i | input | COL_W | Failing column address |
| done_i | input | 1 | End-of-test strobe, latches the verdict |
| unsuc_o | output | 6 | Per-order out-of-spares flags |
| report_valid_o | output | 1 | Verdict latched since the last initialize |
| repair_ok_o | output | 1 | At least one order survived |
| pick_o | output | 3 | Index of the reported order |
| pick_row_o | output | 2*ROW_W | Row entries of the reported order, slot 0 low |
| pick_row_vld_o | output | 2 | Written flags of those row entries |
| pick_col_o | output | 2*COL_W | Column entries of the reported order, slot 0 low |
| pick_col_vld_o | output | 2 | Written flags of those column entries |

## Verification
Every engine result is registered once. `unsuc_o` and the stored entries therefore change at the same rising edge that samples `fail_i` or `init_i`, and the report outputs change at the edge that samples `done_i`. Nothing is delayed further. The bench drives inputs on the falling edge and advances its own reference model at the next rising edge. It compares all outputs one time unit after that edge, so each result is checked in the cycle it is due. It checks `unsuc_o` after every cycle and the report fields after every cycle once a report is present, so both the hold behaviour and the updates on the due edge are covered.

// File: rtl/spare_order_pkg.sv
package spare_order_pkg;

    localparam int NSP_ROW = 2;
    localparam int NSP_COL = 2;
    localparam int N_STEP  = NSP_ROW + NSP_COL;
    localparam int N_ORD   = 6;
    localparam int IDX_W   = $clog2(N_ORD);
    localparam int STEP_W  = $clog2(N_STEP + 1);

    // Allocation order as a mask: MSB is the first spare handed out,
    // a 1 means row spare. Orders are listed by descending mask value.
    function automatic logic [N_STEP-1:0] order_mask(input int idx);
        logic [N_STEP-1:0] res;
        logic [N_STEP-1:0] cand;
        int                k;
        res = '0;
        k   = 0;
        for (int v = (1 << N_STEP) - 1; v >= 0; v--) begin
            cand = v[N_STEP-1:0];
            if ($countones(cand) == NSP_ROW) begin
                if (k == idx) res = cand;
                k++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/spare_cam.sv
module spare_cam #(
    parameter int W = 8,
    parameter int D = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           wr_i,
    input  logic [W-1:0]   data_i,
    input  logic [W-1:0]   key_i,
    output logic           hit_o,
    output logic [D*W-1:0] ent_o,
    output logic [D-1:0]   vld_o
);

    logic [W-1:0] ent [D];
    logic [D-1:0] vld;
    logic [D-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = D - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
            end
        end
    end

    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < D; i++) begin
            if (vld[i] && ent[i] == key_i) hit_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            vld <= '0;
            for (int i = 0; i < D; i++) ent[i] <= '0;
        end else if (wr_i) begin
            for (int i = 0; i < D; i++) begin
                if (sel[i]) begin
                    ent[i] <= data_i;
                    vld[i] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < D; g++) begin : g_pack
        assign ent_o[g*W +: W] = ent[g];
    end
    assign vld_o = vld;

    // R3: written entries are never lost without a clear
    p_vld_grow_r3: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((vld & $past(vld)) == $past(vld)));

    // R3: the owning engine never writes into a full register file
    p_no_wr_full_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !clr_i) |-> !(&vld));

endmodule

// File: rtl/spare_engine.sv
module spare_engine
    import spare_order_pkg::*;
#(
    parameter int                ROW_W = 8,
    parameter int                COL_W = 8,
    parameter logic [N_STEP-1:0] ORDER = 4'b1100
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init_i,
    input  logic                     fail_i,
    input  logic [ROW_W-1:0]         row_i,
    input  logic [COL_W-1:0]         col_i,
    output logic                     unsuc_o,
    output logic [NSP_ROW*ROW_W-1:0] rows_o,
    output logic [NSP_ROW-1:0]       row_vld_o,
    output logic [NSP_COL*COL_W-1:0] cols_o,
    output logic [NSP_COL-1:0]       col_vld_o
);

    logic [STEP_W-1:0] step;
    logic              unsuc;
    logic              row_hit, col_hit;
    logic [N_STEP-1:0] shifted;
    logic              cur_is_row;
    logic              spares_left;
    logic              take;
    logic              wr_row, wr_col;

    assign shifted     = ORDER << step;
    assign cur_is_row  = shifted[N_STEP-1];
    assign spares_left = (step != STEP_W'(N_STEP));
    assign take        = fail_i && !init_i && !unsuc && !(row_hit || col_hit);
    assign wr_row      = take && spares_left && cur_is_row;
    assign wr_col      = take && spares_left && !cur_is_row;

    spare_cam #(.W(ROW_W), .D(NSP_ROW)) u_row_cam (
        .clk(clk), .rst(rst), .clr_i(init_i), .wr_i(wr_row),
        .data_i(row_i), .key_i(row_i), .hit_o(row_hit),
        .ent_o(rows_o), .vld_o(row_vld_o)
    );

    spare_cam #(.W(COL_W), .D(NSP_COL)) u_col_cam (
        .clk(clk), .rst(rst), .clr_i(init_i), .wr_i(wr_col),
        .data_i(col_i), .key_i(col_i), .hit_o(col_hit),
        .ent_o(cols_o), .vld_o(col_vld_o)
    );

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            step  <= '0;
            unsuc <= 1'b0;
        end else if (take) begin
            if (spares_left) step  <= step + 1'b1;
            else             unsuc <= 1'b1;
        end
    end

    assign unsuc_o = unsuc;

    // R4: the out-of-spares flag is sticky until initialize
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (unsuc && !init_i) |=> unsuc);

    // R2: a covered fail leaves the order pointer and flag untouched
    p_covered_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fail_i && !init_i && (row_hit || col_hit)) |=> ($stable(step) && $stable(unsuc)));

    // R6: a pass cycle changes nothing
    p_pass_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!fail_i && !init_i) |=> ($stable(step) && $stable(unsuc) && $stable(row_vld_o) && $stable(col_vld_o)));

    // R4: the flag only rises once all spares are spent
    p_unsuc_full_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(unsuc) |-> ((&row_vld_o) && (&col_vld_o)));

endmodule

// File: rtl/spare_pick.sv
module spare_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  unsuc_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!unsuc_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/spare_order_analyzer.sv
module spare_order_analyzer
    import spare_order_pkg::*;
#(
    parameter int ROW_W = 6,
    parameter int COL_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init_i,
    input  logic                     fail_i,
    input  logic [ROW_W-1:0]         row_i,
    input  logic [COL_W-1:0]         col_i,
    input  logic                     done_i,
    output logic [N_ORD-1:0]         unsuc_o,
    output logic                     report_valid_o,
    output logic                     repair_ok_o,
    output logic [IDX_W-1:0]         pick_o,
    output logic [NSP_ROW*ROW_W-1:0] pick_row_o,
    output logic [NSP_ROW-1:0]       pick_row_vld_o,
    output logic [NSP_COL*COL_W-1:0] pick_col_o,
    output logic [NSP_COL-1:0]       pick_col_vld_o
);

    logic [NSP_ROW*ROW_W-1:0] eng_rows [N_ORD];
    logic [NSP_ROW-1:0]       eng_rvld [N_ORD];
    logic [NSP_COL*COL_W-1:0] eng_cols [N_ORD];
    logic [NSP_COL-1:0]       eng_cvld [N_ORD];

    for (genvar g = 0; g < N_ORD; g++) begin : g_eng
        spare_engine #(
            .ROW_W(ROW_W), .COL_W(COL_W), .ORDER(order_mask(g))
        ) u_eng (
            .clk(clk), .rst(rst), .init_i(init_i), .fail_i(fail_i),
            .row_i(row_i), .col_i(col_i), .unsuc_o(unsuc_o[g]),
            .rows_o(eng_rows[g]), .row_vld_o(eng_rvld[g]),
            .cols_o(eng_cols[g]), .col_vld_o(eng_cvld[g])
        );
    end

    logic             found;
    logic [IDX_W-1:0] sel_idx;

    spare_pick #(.N(N_ORD), .IW(IDX_W)) u_pick (
        .unsuc_i(unsuc_o), .found_o(found), .idx_o(sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            report_valid_o <= 1'b0;
            repair_ok_o    <= 1'b0;
            pick_o         <= '0;
            pick_row_o     <= '0;
            pick_row_vld_o <= '0;
            pick_col_o     <= '0;
            pick_col_vld_o <= '0;
        end else if (done_i) begin
            report_valid_o <= 1'b1;
            repair_ok_o    <= found;
            pick_o         <= sel_idx;
            pick_row_o     <= found ? eng_rows[sel_idx] : '0;
            pick_row_vld_o <= found ? eng_rvld[sel_idx] : '0;
            pick_col_o     <= found ? eng_cols[sel_idx] : '0;
            pick_col_vld_o <= found ? eng_cvld[sel_idx] : '0;
        end
    end

    // R5: initialize clears the failure vector and the report
    p_init_clear_r5: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (unsuc_o == '0 && !report_valid_o));

    // R7: verdict reflects the vector seen at the done edge
    p_verdict_r7: assert property (@(posedge clk) disable iff (rst)
        (done_i && !init_i) |=> (report_valid_o && (repair_ok_o == !(&$past(unsuc_o)))));

    // R9: report holds between done strobes
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (report_valid_o && !init_i && !done_i) |=>
            ($stable(pick_o) && $stable(repair_ok_o) && $stable(pick_row_o) && $stable(pick_col_o)));

    // R8: an unrepairable verdict carries no addresses
    p_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (report_valid_o && !repair_ok_o) |-> (pick_o == '0 && pick_row_vld_o == '0 && pick_col_vld_o == '0));

endmodule

// File: tb/spare_order_analyzer_tb_top.sv
module spare_order_analyzer_tb_top;

    localparam int RW = 6;
    localparam int CW = 5;
    localparam int NE = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          init_i = 1'b0, fail_i = 1'b0, done_i = 1'b0;
    logic [RW-1:0] row_i = '0;
    logic [CW-1:0] col_i = '0;
    logic [NE-1:0] unsuc_o;
    logic          report_valid_o, repair_ok_o;
    logic [2:0]    pick_o;
    logic [2*RW-1:0] pick_row_o;
    logic [1:0]    pick_row_vld_o;
    logic [2*CW-1:0] pick_col_o;
    logic [1:0]    pick_col_vld_o;

    always #2 clk = ~clk;

    spare_order_analyzer #(.ROW_W(RW), .COL_W(CW)) dut_i (
        .clk(clk), .rst(rst), .init_i(init_i), .fail_i(fail_i),
        .row_i(row_i), .col_i(col_i), .done_i(done_i),
        .unsuc_o(unsuc_o), .report_valid_o(report_valid_o),
        .repair_ok_o(repair_ok_o), .pick_o(pick_o),
        .pick_row_o(pick_row_o), .pick_row_vld_o(pick_row_vld_o),
        .pick_col_o(pick_col_o), .pick_col_vld_o(pick_col_vld_o)
    );

    // R1: order table, MSB first, 1 = row spare
    localparam bit [3:0] ORD [NE] = '{4'b1100, 4'b1010, 4'b1001,
                                      4'b0110, 4'b0101, 4'b0011};

    logic [RW-1:0] mr [NE][2];
    bit            mrv [NE][2];
    logic [CW-1:0] mc [NE][2];
    bit            mcv [NE][2];
    int            mstep [NE];
    bit            mun [NE];

    bit              e_rv, e_ok;
    logic [2:0]      e_pick;
    logic [2*RW-1:0] e_rows;
    logic [1:0]      e_rvld;
    logic [2*CW-1:0] e_cols;
    logic [1:0]      e_cvld;

    int n_chk = 0;
    int n_fail = 0;

    function automatic void model_init();
        for (int e = 0; e < NE; e++) begin
            mstep[e] = 0;
            mun[e]   = 1'b0;
            for (int s = 0; s < 2; s++) begin
                mr[e][s] = '0; mrv[e][s] = 1'b0;
                mc[e][s] = '0; mcv[e][s] = 1'b0;
            end
        end
        e_rv = 0; e_ok = 0; e_pick = '0;
        e_rows = '0; e_rvld = '0; e_cols = '0; e_cvld = '0;
    endfunction

    function automatic void model_fail(logic [RW-1:0] r, logic [CW-1:0] c);
        for (int e = 0; e < NE; e++) begin
            bit cov;
            cov = 1'b0;
            for (int s = 0; s < 2; s++) begin
                if (mrv[e][s] && mr[e][s] == r) cov = 1'b1;
                if (mcv[e][s] && mc[e][s] == c) cov = 1'b1;
            end
            if (!cov && !mun[e]) begin
                if (mstep[e] == 4) mun[e] = 1'b1;
                else begin
                    if (ORD[e][3 - mstep[e]]) begin
                        if (!mrv[e][0]) begin mr[e][0] = r; mrv[e][0] = 1'b1; end
                        else            begin mr[e][1] = r; mrv[e][1] = 1'b1; end
                    end else begin
                        if (!mcv[e][0]) begin mc[e][0] = c; mcv[e][0] = 1'b1; end
                        else            begin mc[e][1] = c; mcv[e][1] = 1'b1; end
                    end
                    mstep[e]++;
                end
            end
        end
    endfunction

    function automatic void model_done();
        int w;
        w = -1;
        for (int e = NE - 1; e >= 0; e--) if (!mun[e]) w = e;
        e_rv = 1;
        e_ok = (w >= 0);
        e_pick = '0; e_rows = '0; e_rvld = '0; e_cols = '0; e_cvld = '0;
        if (w >= 0) begin
            e_pick = 3'(w);
            e_rows = {mr[w][1], mr[w][0]};
            e_rvld = {2'(mrv[w][1]), 1'b0} | 2'(mrv[w][0]);
            e_cols = {mc[w][1], mc[w][0]};
            e_cvld = {2'(mcv[w][1]), 1'b0} | 2'(mcv[w][0]);
        end
    endfunction

    function automatic logic [NE-1:0] exp_unsuc();
        logic [NE-1:0] v;
        for (int e = 0; e < NE; e++) v[e] = mun[e];
        return v;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "unsuc_o", 32'(unsuc_o), 32'(exp_unsuc()));
        chk(tag, "report_valid_o", 32'(report_valid_o), 32'(e_rv));
        if (e_rv || report_valid_o) begin
            chk("R7", "repair_ok_o", 32'(repair_ok_o), 32'(e_ok));
            chk("R8", "pick_o", 32'(pick_o), 32'(e_pick));
            chk("R8", "pick_row_o", 32'(pick_row_o), 32'(e_rows));
            chk("R8", "pick_row_vld_o", 32'(pick_row_vld_o), 32'(e_rvld));
            chk("R8", "pick_col_o", 32'(pick_col_o), 32'(e_cols));
            chk("R8", "pick_col_vld_o", 32'(pick_col_vld_o), 32'(e_cvld));
        end
    endtask

    task automatic cyc(bit ini, bit fl, int r, int c, bit dn, string tag);
        @(negedge clk);
        init_i = ini; fail_i = fl; done_i = dn;
        row_i = RW'(r); col_i = CW'(c);
        @(posedge clk);
        if (ini) model_init();
        else begin
            if (dn) model_done();
            if (fl) model_fail(RW'(r), CW'(c));
        end
        #1;
        compare_all(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = 0;
        void'($urandom(32'd1234));
        model_init();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 compare_all("R5");                          // R5 reset state

        // R7 R8: no fails -> order 0 reported, nothing stored
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, 0, "R9");

        // R4: five distinct fails exhaust every order
        cyc(1, 0, 0, 0, 0, "R5");
        for (int k = 1; k <= 4; k++) cyc(0, 1, k, k, 0, "R3");
        chk("R4", "unsuc before extra fail", 32'(unsuc_o), 32'h0);
        cyc(0, 1, 5, 5, 0, "R4");
        chk("R4", "all orders out", 32'(unsuc_o), 32'h3f);
        cyc(0, 1, 6, 6, 0, "R4");
        cyc(0, 0, 0, 0, 1, "R8");
        chk("R8", "unrepairable verdict", 32'(repair_ok_o), 32'h0);

        // R2 R6: repeated fail, passes, row-matching fail
        cyc(1, 0, 0, 0, 0, "R5");
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, 0, "R2");
        cyc(0, 0, 9, 9, 0, "R6");
        cyc(0, 1, 1, 7, 0, "R2");
        cyc(0, 1, 3, 1, 0, "R2");
        cyc(0, 0, 0, 0, 1, "R8");

        // one failing row then a second row sharing a column
        cyc(1, 0, 0, 0, 0, "R5");
        for (int k = 0; k < 4; k++) cyc(0, 1, 2, k, 0, "R3");
        cyc(0, 1, 5, 0, 0, "R3");
        cyc(0, 1, 6, 0, 0, "R3");
        cyc(0, 1, 7, 3, 0, "R4");
        cyc(0, 0, 0, 0, 1, "R8");
        // R9: later fails leave the report alone
        for (int k = 0; k < 6; k++) cyc(0, 1, 10 + k, 20 + k, 0, "R9");
        chk("R9", "vector moved on", 32'(unsuc_o), 32'h3f);

        // R5: initialize beats a simultaneous fail and done
        cyc(1, 1, 4, 4, 1, "R5");
        cyc(0, 0, 0, 0, 1, "R5");
        chk("R5", "no entries after init+fail", 32'({pick_row_vld_o, pick_col_vld_o}), 32'h0);

        // random blocks over a small address space
        for (int blk = 0; blk < 60; blk++) begin
            int nf;
            cyc(1, 0, 0, 0, 0, "R5");
            nf = int'($urandom_range(0, 9));
            for (int k = 0; k < nf; k++) begin
                if ($urandom_range(0, 3) == 0) cyc(0, 0, 0, 0, 0, "R6");
                cyc(0, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 0, "R3");
            end
            cyc(0, 0, 0, 0, 1, "R8");
            cyc(0, 1, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 0, "R9");
            cyc(0, 0, 0, 0, 0, "R9");
        end

        finish_run();
    end

endmodule